// File: doc/BRIEF.md
# Serial Voice Sample Timeslot Port

This block connects one voice channel to a shared time-division serial highway. A bit clock from outside times every transfer, and a frame pulse marks the start of each frame. Inside, a bit position counter restarts on every frame pulse. When the counter reaches a programmable transmit position, the block drives one sample onto the outgoing serial line. When it reaches a separate receive position, it gathers one sample from the incoming serial line. Outside its own slot the outgoing line is released, so that other channels on the same highway can drive it.

The transmit and receive positions are set independently, in bit clock counts from the frame pulse. Timeslot layouts such as long and short frame pulses, interleaved dual-channel slots and offset slots are therefore only a matter of choosing these two numbers. The sample width is either 8 bits, for normal operation, or 16 bits, for test. The outgoing line can be released either half a bit early, on the falling edge inside the last bit, or at the following rising edge. The early release avoids overlap with a driver in the next slot. A position that the counter never reaches within a frame turns that direction off with no further effect. Encoding of the sample values, clock generation and register access belong to neighbouring blocks.

Top module: `pcm_slot_port`

## Requirements
- R1: The bit position counter becomes 0 at the rising `pclk` edge where `fsync` is sampled high, and increases by 1 on each later rising edge. After reset, no transfer takes place in either direction until the first `fsync`.
- R2: With transmit position S and sample length N, `dtx_oe` is high and `dtx_data` carries the sample MSB first during counts S to S+N-1. Each bit is launched on a rising `pclk` edge.
- R3: The transmit sample is taken from `tx_word` at the rising edge where the count becomes S. A change on `tx_word` after that edge does not alter the sample being sent.
- R4: When `rel_fall`=1, `dtx_oe` falls at the falling `pclk` edge inside the last bit of the sample. When `rel_fall`=0, it falls at the next rising edge.
- R5: With receive position R, `drx` is sampled MSB first on the falling `pclk` edges of counts R to R+N-1. The word appears on `rx_word` together with a `rx_valid` pulse one `pclk` cycle long, during count R+N. `rx_word` holds its value between pulses.
- R6: `wide_mode`=0 selects N=8: the transmit sample is `tx_word[7:0]`, and the received sample is placed in `rx_word[7:0]` with bits 15:8 zero. `wide_mode`=1 selects N=16, using all of `tx_word` and `rx_word`.
- R7: A position the counter never reaches in a frame causes no transfer in that direction. The counter holds at its maximum value of 1023 and does not wrap, so in a frame longer than 1024 counts a position is matched at most once.
- R8: `dtx_oe` is low outside the transmit slot. In reset, `dtx_oe` and `rx_valid` are 0 and `rx_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame pulse, sampled on the rising edge |
| tx_start | input | 10 | Transmit slot position in bit counts |
| rx_start | input | 10 | Receive slot position in bit counts |
| wide_mode | input | 1 | 1 selects 16-bit samples, 0 selects 8-bit samples |
| rel_fall | input | 1 | 1 releases the line on the falling edge inside the last bit |
| tx_word | input | 16 | Holding register for the next transmit sample |
| drx | input | 1 | Incoming serial data |
| dtx_data | output | 1 | Outgoing serial data |
| dtx_oe | output | 1 | Output enable for the outgoing line; low means released |
| rx_word | output | 16 | Last received sample |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` is updated |

## Verification
The hardest case to reach is the counter holding at its maximum in a frame that runs past 1024 counts. Both a wrapping counter and a saturating one behave the same until the count would pass the transmit position a second time. The stimulus uses one frame of 1100 counts, so a wrapping counter would send a second sample at count 1029. It also uses a frame whose transmit slot begins at count 1020 and continues through the saturation point. The half-cycle release is checked by sampling the enable just after each falling edge. The rising-edge release is checked at the following rising edge.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

  // Number of bits in one sample for the selected format.
  function automatic int slot_len(input logic wide, input int wide_w, input int narrow_w);
    return wide ? wide_w : narrow_w;
  endfunction

  // True when a given count falls inside a slot that starts at pos.
  function automatic logic in_slot(input int cnt, input int pos, input int len);
    return (cnt >= pos) && (cnt < pos + len);
  endfunction

endpackage

// File: rtl/pcm_frame_counter.sv
module pcm_frame_counter #(
  parameter int CNT_W = 10
) (
  input  logic             pclk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic [CNT_W-1:0] tx_start,
  input  logic [CNT_W-1:0] rx_start,
  output logic             tx_fire,
  output logic             rx_fire
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             live_q, live_d;

  // A count is live from a frame pulse until it saturates at its maximum.
  always_comb begin
    if (fsync) begin
      cnt_d  = '0;
      live_d = 1'b1;
    end else if (!live_q || cnt_q == CMAX) begin
      cnt_d  = cnt_q;
      live_d = 1'b0;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      live_d = 1'b1;
    end
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CMAX;
      live_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      live_q <= live_d;
    end
  end

  // Transmit compares the count about to take effect; receive the current one.
  assign tx_fire = live_d && (cnt_d == tx_start);
  assign rx_fire = live_q && (cnt_q == rx_start);

  AST_CNT_RESTART: assert property (@(posedge pclk) disable iff (!rst_n)
    fsync |=> (cnt_q == '0) && live_q); // R1
  AST_CNT_STEP: assert property (@(posedge pclk) disable iff (!rst_n)
    (!fsync && live_q && cnt_q != CMAX) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1
  AST_TX_POS: assert property (@(posedge pclk) disable iff (!rst_n)
    tx_fire |=> (cnt_q == $past(tx_start))); // R2
  AST_NO_WRAP: assert property (@(posedge pclk) disable iff (!rst_n)
    (!fsync && cnt_q == CMAX) |=> (cnt_q == CMAX) && !live_q); // R7

endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
  import pcm_slot_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int NARROW_W = 8
) (
  input  logic                pclk,
  input  logic                rst_n,
  input  logic                tx_fire,
  input  logic                wide_mode,
  input  logic                rel_fall,
  input  logic [SAMPLE_W-1:0] tx_word,
  output logic                dtx_data,
  output logic                dtx_oe
);
  localparam int LEFT_W = $clog2(SAMPLE_W + 1);

  logic [SAMPLE_W-1:0] sh_q;
  logic [LEFT_W-1:0]   left_q;
  logic                cut_q;
  logic                tx_active;
  logic                tx_last;

  assign tx_active = (left_q != '0);
  assign tx_last   = (left_q == LEFT_W'(1));

  // Load aligns the sample so that its MSB sits at the top of the shifter.
  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (tx_fire) begin
      sh_q   <= wide_mode ? tx_word : (tx_word << (SAMPLE_W - NARROW_W));
      left_q <= LEFT_W'(slot_len(wide_mode, SAMPLE_W, NARROW_W));
    end else if (tx_active) begin
      sh_q   <= sh_q << 1;
      left_q <= left_q - 1'b1;
    end
  end

  // Half-cycle early release inside the last bit.
  always_ff @(negedge pclk or negedge rst_n) begin
    if (!rst_n) cut_q <= 1'b0;
    else        cut_q <= tx_last && rel_fall;
  end

  assign dtx_data = sh_q[SAMPLE_W-1];
  assign dtx_oe   = tx_active && !(cut_q && tx_last);

  AST_TX_DRIVE: assert property (@(posedge pclk) disable iff (!rst_n)
    tx_fire |=> dtx_oe); // R2
  AST_TX_RELEASE: assert property (@(posedge pclk) disable iff (!rst_n)
    (tx_last && !tx_fire) |=> !dtx_oe); // R4
  AST_TX_IDLE: assert property (@(posedge pclk) disable iff (!rst_n)
    (!tx_active && !tx_fire) |=> !dtx_oe); // R8

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
  import pcm_slot_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int NARROW_W = 8
) (
  input  logic                pclk,
  input  logic                rst_n,
  input  logic                rx_fire,
  input  logic                wide_mode,
  input  logic                drx,
  output logic [SAMPLE_W-1:0] rx_word,
  output logic                rx_valid
);
  localparam int LEFT_W = $clog2(SAMPLE_W + 1);
  localparam logic [SAMPLE_W-1:0] NMASK = {{(SAMPLE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [SAMPLE_W-1:0] sh_q;
  logic [LEFT_W-1:0]   left_q;
  logic                wide_q;
  logic                done_q;

  // Bits are taken on the falling edge, in the middle of each bit period.
  always_ff @(negedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      wide_q <= 1'b0;
      done_q <= 1'b0;
    end else if (rx_fire) begin
      sh_q   <= {sh_q[SAMPLE_W-2:0], drx};
      left_q <= LEFT_W'(slot_len(wide_mode, SAMPLE_W, NARROW_W) - 1);
      wide_q <= wide_mode;
      done_q <= 1'b0;
    end else if (left_q != '0) begin
      sh_q   <= {sh_q[SAMPLE_W-2:0], drx};
      left_q <= left_q - 1'b1;
      done_q <= (left_q == LEFT_W'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  // Hand the finished word into the rising-edge domain as a one-cycle pulse.
  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= done_q;
      if (done_q) rx_word <= wide_q ? sh_q : (sh_q & NMASK);
    end
  end

  AST_RX_ONE_SHOT: assert property (@(posedge pclk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R5
  AST_RX_HOLD: assert property (@(posedge pclk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_word)); // R5
  AST_RX_NARROW: assert property (@(posedge pclk) disable iff (!rst_n)
    (rx_valid && !wide_q) |-> ((rx_word & ~NMASK) == '0)); // R6

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int CNT_W    = 10,
  parameter int SAMPLE_W = 16,
  parameter int NARROW_W = 8
) (
  input  logic                pclk,
  input  logic                rst_n,
  input  logic                fsync,
  input  logic [CNT_W-1:0]    tx_start,
  input  logic [CNT_W-1:0]    rx_start,
  input  logic                wide_mode,
  input  logic                rel_fall,
  input  logic [SAMPLE_W-1:0] tx_word,
  input  logic                drx,
  output logic                dtx_data,
  output logic                dtx_oe,
  output logic [SAMPLE_W-1:0] rx_word,
  output logic                rx_valid
);
  logic tx_fire;
  logic rx_fire;

  pcm_frame_counter #(.CNT_W(CNT_W)) u_count (
    .pclk     (pclk),
    .rst_n    (rst_n),
    .fsync    (fsync),
    .tx_start (tx_start),
    .rx_start (rx_start),
    .tx_fire  (tx_fire),
    .rx_fire  (rx_fire)
  );

  pcm_tx_lane #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W)) u_tx (
    .pclk      (pclk),
    .rst_n     (rst_n),
    .tx_fire   (tx_fire),
    .wide_mode (wide_mode),
    .rel_fall  (rel_fall),
    .tx_word   (tx_word),
    .dtx_data  (dtx_data),
    .dtx_oe    (dtx_oe)
  );

  pcm_rx_lane #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W)) u_rx (
    .pclk      (pclk),
    .rst_n     (rst_n),
    .rx_fire   (rx_fire),
    .wide_mode (wide_mode),
    .drx       (drx),
    .rx_word   (rx_word),
    .rx_valid  (rx_valid)
  );

  AST_FIRE_NEEDS_RUN: assert property (@(posedge pclk) disable iff (!rst_n)
    $rose(dtx_oe) |-> $past(tx_fire) || $past(fsync) || tx_fire || 1'b1 ? $past(tx_fire) : 1'b0); // R1

endmodule

// File: tb/pcm_slot_port_test.sv
`timescale 1ns/1ps
module pcm_slot_port_test;

  typedef struct packed {
    logic [10:0] len;
    logic [9:0]  txs;
    logic [9:0]  rxs;
    logic        wide;
    logic        relf;
    logic [15:0] txw;
    logic [15:0] rxw;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{11'd32,   10'd1,    10'd1,    1'b0, 1'b1, 16'h00A5, 16'h003C},
    '{11'd32,   10'd0,    10'd9,    1'b0, 1'b0, 16'h0081, 16'h007E},
    '{11'd64,   10'd20,   10'd3,    1'b1, 1'b1, 16'hBEEF, 16'h1234},
    '{11'd64,   10'd30,   10'd40,   1'b1, 1'b0, 16'h8001, 16'hF00D},
    '{11'd64,   10'd300,  10'd70,   1'b0, 1'b1, 16'h00FF, 16'h00FF},
    '{11'd1100, 10'd5,    10'd9,    1'b0, 1'b1, 16'h005A, 16'h00C3},
    '{11'd1040, 10'd1020, 10'd1016, 1'b0, 1'b0, 16'h0096, 16'h0069},
    '{11'd40,   10'd2,    10'd20,   1'b1, 1'b1, 16'h0F0F, 16'hAAAA},
    '{11'd16,   10'd8,    10'd0,    1'b0, 1'b1, 16'h1201, 16'h0080}
  };

  logic        pclk = 1'b0;
  logic        rst_n;
  logic        fsync;
  logic [9:0]  tx_start;
  logic [9:0]  rx_start;
  logic        wide_mode;
  logic        rel_fall;
  logic [15:0] tx_word;
  logic        drx;
  logic        dtx_data;
  logic        dtx_oe;
  logic [15:0] rx_word;
  logic        rx_valid;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 pclk = ~pclk;

  pcm_slot_port uut (
    .pclk      (pclk),
    .rst_n     (rst_n),
    .fsync     (fsync),
    .tx_start  (tx_start),
    .rx_start  (rx_start),
    .wide_mode (wide_mode),
    .rel_fall  (rel_fall),
    .tx_word   (tx_word),
    .drx       (drx),
    .dtx_data  (dtx_data),
    .dtx_oe    (dtx_oe),
    .rx_word   (rx_word),
    .rx_valid  (rx_valid)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // One frame: fsync for the first count, then len-1 counts without it.
  task automatic run_frame(input vec_t v);
    int len, txs, rxs, n;
    logic [15:0] wexp;
    len = int'(v.len);
    txs = int'(v.txs);
    rxs = int'(v.rxs);
    n   = v.wide ? 16 : 8;
    wexp = v.wide ? v.rxw : (v.rxw & 16'h00FF);
    tx_start  = v.txs;
    rx_start  = v.rxs;
    wide_mode = v.wide;
    rel_fall  = v.relf;
    tx_word   = v.txw;
    fsync     = 1'b1;
    for (int c = 0; c < len; c++) begin
      logic tx_on, rx_on;
      @(posedge pclk); #0.5;
      if (c == 0) fsync = 1'b0;
      tx_on = (c >= txs) && (c < txs + n);
      rx_on = (c >= rxs) && (c < rxs + n);
      check(tx_on ? "R2 enable" : "R8 idle", {15'd0, dtx_oe}, {15'd0, tx_on});
      if (tx_on) check("R2/R3/R6 data bit", {15'd0, dtx_data}, {15'd0, v.txw[n-1-(c-txs)]});
      if (c == txs) tx_word = ~v.txw; // R3 late change must not leak
      drx = rx_on ? v.rxw[n-1-(c-rxs)] : c[0];
      check("R5 valid", {15'd0, rx_valid}, {15'd0, (c == rxs + n)});
      if (c == rxs + n) check("R5/R6 word", rx_word, wexp);
      #2;
      check("R4 release", {15'd0, dtx_oe}, {15'd0, tx_on && !(v.relf && c == txs + n - 1)});
    end
  endtask

  initial begin
    #80000;
    n_fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fsync = 1'b0; tx_start = '1; rx_start = '1;
    wide_mode = 1'b0; rel_fall = 1'b0; tx_word = '0; drx = 1'b1;
    repeat (3) @(posedge pclk);
    #0.5;
    check("R8 reset oe", {15'd0, dtx_oe}, 16'd0);
    check("R8 reset valid", {15'd0, rx_valid}, 16'd0);
    check("R8 reset word", rx_word, 16'd0);
    rst_n = 1'b1;
    tx_start = '0; rx_start = '0; tx_word = 16'hFFFF;
    // R1: positions 0 and upward must not fire before the first frame pulse
    for (int i = 0; i < 20; i++) begin
      @(posedge pclk); #0.5;
      check("R1 idle oe", {15'd0, dtx_oe}, 16'd0);
      check("R1 idle valid", {15'd0, rx_valid}, 16'd0);
    end
    for (int k = 0; k < NVEC; k++) run_frame(VECS[k]);
    // Second 8-bit frame right after a 16-bit one, back-to-back slots at 0
    run_frame('{11'd24, 10'd0, 10'd0, 1'b1, 1'b0, 16'hC3A5, 16'h5AC3});
    run_frame('{11'd24, 10'd0, 10'd0, 1'b0, 1'b1, 16'hFF7E, 16'hFFE7});
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule